// File: doc/BRIEF.md
# Cascadable Loadable Binary Counter

This block is a synchronous binary up-counter built from identical stages of a parameterized width. Each stage has a synchronous clear, a synchronous parallel load, a count enable, an all-ones flag and an enable-out that carries the count onward. The top module chains a parameterized number of stages into one wider counter. Each stage's enable-out drives the next stage's enable. Clock, clear and load are shared by all stages, and stage 0 holds the least significant bits.

Clear wins over everything. Load wins over counting and does not need the enable. Counting happens only while the enable is high. The all-ones flag and the enable-out are combinational functions of the registered count and the present enable, so a carry ripples through the chain within the same cycle.

Top module: `bincnt_chain`

## Requirements
- R1: When `rst` is high at a rising edge of `clk`, `count` becomes zero, whatever `load`, `cnt_en` and `din` are. `term` and `en_out` are low after that edge.
- R2: When `rst` is low and `load` is high at a rising edge, `count` takes the value of `din`, whether `cnt_en` is high or low.
- R3: When `rst` and `load` are low and `cnt_en` is high at a rising edge, `count` increases by one.
- R4: When `rst`, `load` and `cnt_en` are all low at a rising edge, `count` keeps its value whatever `din` is.
- R5: `term` is high exactly when every bit of `count` is one. It follows the registered count with no extra register.
- R6: `en_out` is high exactly when `term` and `cnt_en` are both high. It is low whenever `cnt_en` is low, even at all ones.
- R7: An increment from all ones gives zero, and `term` falls on that same edge.
- R8: The STAGES stages of STAGE_W bits act as one counter of STAGE_W*STAGES bits. A lower stage's enable-out carries into the next stage, so every increment crosses stage boundaries.
- R9: Before any clock edge, `count` is zero and `term` and `en_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous clear, highest priority |
| load | input | 1 | Synchronous parallel load, independent of the enable |
| cnt_en | input | 1 | Count enable into stage 0 |
| din | input | STAGE_W*STAGES | Parallel load value |
| count | output | STAGE_W*STAGES | Registered count value |
| term | output | 1 | High when count is all ones |
| en_out | output | 1 | Enable-out of the last stage, for further cascading |

## Verification
Clear, load, increment and hold each show on `count` exactly one rising edge after the control values are applied. The bench therefore drives inputs at the falling edge and compares `count` one time unit after the next rising edge. `term` and `en_out` are combinational on the registered count and the present `cnt_en`, so they are due in the same cycle. They are checked after the falling-edge drive settles and before the next rising edge. A full pass through every value of the 8-bit default counter tests the carry between stages and the wrap at all ones against a model held in the bench.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_INC   = 2'd1,
      OP_LOAD  = 2'd2,
      OP_CLEAR = 2'd3
   } cnt_op_e;

   // Priority: clear, then load (ignores enable), then increment, then hold.
   function automatic cnt_op_e pick_op(input logic clr, input logic ld, input logic en);
      if (clr)      return OP_CLEAR;
      else if (ld)  return OP_LOAD;
      else if (en)  return OP_INC;
      else          return OP_HOLD;
   endfunction

endpackage

// File: rtl/bincnt_allones.sv
module bincnt_allones #(
   parameter int unsigned WIDTH = 4,
   parameter int unsigned GROUP = 4
) (
   input  logic [WIDTH-1:0] vec,
   output logic             all
);
   localparam int unsigned GROUPS = (WIDTH + GROUP - 1) / GROUP;
   localparam int unsigned PADW   = GROUPS * GROUP;

   if (WIDTH < 1) begin : g_bad_width
      $error("bincnt_allones: WIDTH must be at least 1");
   end
   if (GROUP < 2) begin : g_bad_group
      $error("bincnt_allones: GROUP must be at least 2");
   end

   if (WIDTH <= GROUP) begin : g_flat
      assign all = &vec;
   end else begin : g_tree
      logic [PADW-1:0]   padded;
      logic [GROUPS-1:0] part;

      always_comb begin
         padded            = '1;
         padded[WIDTH-1:0] = vec;
      end

      for (genvar g = 0; g < GROUPS; g++) begin : g_part
         assign part[g] = &padded[g*GROUP +: GROUP];
      end

      assign all = &part;
   end
endmodule

// File: rtl/bincnt_stage.sv
module bincnt_stage
   import cnt_pkg::*;
#(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ld,
   input  logic             ce,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q,
   output logic             tc,
   output logic             ceo
);
   if (WIDTH < 2) begin : g_bad_width
      $error("bincnt_stage: WIDTH must be at least 2");
   end

   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   logic [WIDTH-1:0] q_r = '0;
   cnt_op_e          op;

   always_comb op = pick_op(rst, ld, ce);

   always_ff @(posedge clk) begin
      case (op)
         OP_CLEAR: q_r <= '0;
         OP_LOAD:  q_r <= d;
         OP_INC:   q_r <= q_r + ONE;
         default:  q_r <= q_r;
      endcase
   end

   bincnt_allones #(.WIDTH(WIDTH), .GROUP(4)) u_tc (
      .vec (q_r),
      .all (tc)
   );

   assign ceo = tc & ce;
   assign q   = q_r;

   p_clear_r1: assert property (@(posedge clk) rst |=> (q == '0 && !tc));
   p_load_r2:  assert property (@(posedge clk) disable iff (rst)
                  ld |=> q == $past(d));
   p_inc_r3:   assert property (@(posedge clk) disable iff (rst)
                  (!ld && ce) |=> q == $past(q) + ONE);
   p_hold_r4:  assert property (@(posedge clk) disable iff (rst)
                  (!ld && !ce) |=> $stable(q));
   p_tc_r5:    assert property (@(posedge clk) disable iff (rst)
                  (q == '1) == tc);
   p_ceo_r6:   assert property (@(posedge clk) disable iff (rst)
                  !ce |-> !ceo);
   p_wrap_r7:  assert property (@(posedge clk) disable iff (rst)
                  (!ld && ceo) |=> (q == '0 && !tc));
endmodule

// File: rtl/bincnt_chain.sv
module bincnt_chain #(
   parameter int unsigned STAGE_W = 4,
   parameter int unsigned STAGES  = 2
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         load,
   input  logic                         cnt_en,
   input  logic [STAGE_W*STAGES-1:0]    din,
   output logic [STAGE_W*STAGES-1:0]    count,
   output logic                         term,
   output logic                         en_out
);
   localparam int unsigned TOTAL_W = STAGE_W * STAGES;
   localparam logic [TOTAL_W-1:0] ONE = TOTAL_W'(1);

   if (STAGE_W < 2) begin : g_bad_w
      $error("bincnt_chain: STAGE_W must be at least 2");
   end
   if (STAGES < 1) begin : g_bad_n
      $error("bincnt_chain: STAGES must be at least 1");
   end

   logic [STAGES:0]   carry;
   logic [STAGES-1:0] stage_tc;

   assign carry[0] = cnt_en;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      bincnt_stage #(.WIDTH(STAGE_W)) u_stage (
         .clk (clk),
         .rst (rst),
         .ld  (load),
         .ce  (carry[i]),
         .d   (din[i*STAGE_W +: STAGE_W]),
         .q   (count[i*STAGE_W +: STAGE_W]),
         .tc  (stage_tc[i]),
         .ceo (carry[i+1])
      );
   end

   assign term   = &stage_tc;
   assign en_out = carry[STAGES];

   p_chain_inc_r8:  assert property (@(posedge clk) disable iff (rst)
                       (!load && cnt_en) |=> count == $past(count) + ONE);
   p_chain_hold_r4: assert property (@(posedge clk) disable iff (rst)
                       (!load && !cnt_en) |=> $stable(count));
   p_chain_term_r5: assert property (@(posedge clk) disable iff (rst)
                       term == (count == '1));
   p_chain_eo_r6:   assert property (@(posedge clk) disable iff (rst)
                       en_out == (term && cnt_en));
   p_chain_clr_r1:  assert property (@(posedge clk)
                       rst |=> (count == '0 && !term && !en_out));
endmodule

// File: tb/bincnt_chain_tb.sv
module bincnt_chain_tb;
   localparam int W   = 8;
   localparam int NV  = 12;
   localparam logic [W-1:0] ALL1 = '1;

   // {rst,ld,ce,0} nibble, din byte, expected count byte after the edge
   localparam logic [19:0] VEC [NV] = '{
      20'h80000,  // R1 clear
      20'h43C3C,  // R2 load with enable low
      20'h2003D,  // R3 increment
      20'h0FF3D,  // R4 hold, din ignored
      20'h2003E,  // R3 increment
      20'h6FEFE,  // R2 load with enable high
      20'h200FF,  // R3 reach all ones
      20'h000FF,  // R6 hold at all ones, enable low
      20'h20000,  // R7 wrap
      20'h60F0F,  // R2 load
      20'h20010,  // R8 carry into stage 1
      20'hEAA00   // R1 clear during load
   };

   logic         clk = 1'b0;
   logic         rst = 1'b0;
   logic         load = 1'b0;
   logic         cnt_en = 1'b0;
   logic [W-1:0] din = '0;
   logic [W-1:0] count;
   logic         term;
   logic         en_out;

   int total = 0;
   int bad   = 0;
   logic [W-1:0] model = '0;
   bit done = 0;

   always #10 clk = ~clk;

   bincnt_chain #(.STAGE_W(4), .STAGES(2)) u_dut (
      .clk(clk), .rst(rst), .load(load), .cnt_en(cnt_en),
      .din(din), .count(count), .term(term), .en_out(en_out)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic r, input logic l, input logic e,
                       input logic [W-1:0] d, input logic [W-1:0] exp, input string req);
      @(negedge clk);
      rst = r; load = l; cnt_en = e; din = d;
      #1;
      chk("R5 term", W'(term), W'(model == ALL1));
      chk("R6 en_out", W'(en_out), W'((model == ALL1) && e));
      @(posedge clk);
      #1;
      chk(req, count, exp);
      model = exp;
   endtask

   initial begin
      #400000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #1;
      chk("R9 count", count, '0);
      chk("R9 term", W'(term), '0);
      chk("R9 en_out", W'(en_out), '0);

      for (int i = 0; i < NV; i++) begin
         logic [19:0] v;
         v = VEC[i];
         step(v[19], v[18], v[17], v[15:8], v[7:0], "R1-R8 vector");
      end

      // R1: clear from all ones with enable high
      step(1'b0, 1'b1, 1'b0, ALL1, ALL1, "R2 load all ones");
      step(1'b1, 1'b0, 1'b1, 8'h55, 8'h00, "R1 clear at all ones");
      #1;
      chk("R1 term after clear", W'(term), '0);
      chk("R1 en_out after clear", W'(en_out), '0);

      // R8/R7: full count through every value, carry and wrap
      for (int n = 0; n < 256; n++) begin
         step(1'b0, 1'b0, 1'b1, 8'hA5, model + 8'd1, "R8 chained increment");
      end
      chk("R7 wrap back to start", count, 8'h00);

      // R4: long hold with changing din
      for (int n = 0; n < 4; n++) begin
         step(1'b0, 1'b0, 1'b0, 8'(n * 37), 8'h00, "R4 hold");
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule